// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block carries out the embedded erase algorithm of a block-partitioned flash array. A single-cycle start pulse hands it a mask of selected blocks and a mask of protected blocks. It erases every block that is selected and not protected, working from the lowest index upward. For each such block it first writes zero to every word. It then issues erase pulses, and after each pulse it reads the whole block back to check that every word is all ones. It drives the array through a plain word-wide port: an address, a program strobe, an erase strobe and read data.

While the sequence runs, the engine holds `busy` and ignores any further start or software-reset request. A normal finish gives a one-cycle `done` pulse and returns the engine to Read. If a block still fails verify after the allowed number of erase pulses, the engine locks up: `busy` and `fail` stay high and `fail_blk` names the block that failed. Only a software reset or a hardware reset releases this lock. If every selected block is protected, the array is not touched at all, and the engine returns to Read after a fixed wait of about 100 µs.

The array address is the block index times `WORDS_PER_BLK` plus the word offset. `WORDS_PER_BLK` must be a power of two.

Top module: `flash_erase_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs are `busy`=0, `done`=0, `fail`=0, `fail_blk`=0, `arr_prog`=0 and `arr_erase`=0.
- R2: Before a block's first erase pulse, every word of that block gets a program strobe. A program strobe writes zero to word `blk*WORDS_PER_BLK+word`.
- R3: After each erase pulse the engine reads the block back word by word. The block counts as finished only when every word reads all ones.
- R4: A block that is protected, or that is not selected, receives no program strobe and no erase strobe.
- R5: Blocks are processed in ascending index order.
- R6: A block receives erase pulses until it verifies, up to `MAX_PULSES`. A block that clears after k pulses receives exactly k pulses.
- R7: If a block fails verify after `MAX_PULSES` pulses, then `fail`=1, `busy`=1 and `fail_blk` holds that block's index. No further strobes are issued, and higher blocks are left untouched.
- R8: In the failed state, a start request has no effect. A `sw_reset` pulse returns the engine to Read on the next cycle, with `busy`=0 and `fail`=0.
- R9: When no selected block is unprotected, `busy` stays high for exactly `NOOP_WAIT` cycles with no array strobes, and then `done` pulses.
- R10: While the engine is running and not failed, `start` and `sw_reset` are ignored.
- R11: On completion, `done` is high for exactly one cycle: the first cycle in which `busy` is low.
- R12: Raising `rst` during an erase ends it at once. In the next cycle `busy` is 0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| start | input | 1 | Begin an erase with the given masks |
| sw_reset | input | 1 | Software reset; leaves the failed state |
| sel_mask | input | NUM_BLK | Blocks selected for erase |
| prot_mask | input | NUM_BLK | Blocks protected against erase |
| arr_addr | output | BLK_W+WORD_W | Array word address {block, word} |
| arr_prog | output | 1 | Program the addressed word to zero |
| arr_erase | output | 1 | One erase pulse on the addressed block |
| arr_rdata | input | DATA_W | Read data at arr_addr, same cycle |
| busy | output | 1 | Embedded operation in progress |
| done | output | 1 | One-cycle pulse on return to Read |
| fail | output | 1 | Locked after an erase failure |
| fail_blk | output | BLK_W | Index of the failed block |

## Verification
Most internal faults in this block show up at the array strobes within a few cycles. A wrong pending mask or a wrong block cursor produces program or erase strobes on a protected block, or in the wrong order, as soon as the next block starts. A broken word counter leaves words unprogrammed before the first erase pulse. A wrong pulse counter changes the per-block pulse count, and with it the cycle in which `fail` rises. A bad wait counter shifts the no-op `busy` length by whole cycles. A fault in the lock logic shows up as `busy` or `fail` dropping without a `sw_reset`.

// File: rtl/efe_pkg.sv
package efe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ERASE,
        ST_VERIFY,
        ST_WAIT,
        ST_FAIL
    } efe_state_e;

    typedef struct packed {
        logic prog;
        logic erase;
    } arr_strobe_t;

    // index width that stays at least one bit wide
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/efe_blk_picker.sv
module efe_blk_picker #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = efe_pkg::idx_w(NUM_BLK)
) (
    input  logic [NUM_BLK-1:0] mask,
    output logic               any,
    output logic [BLK_W-1:0]   first
);
    logic [NUM_BLK:0]   seen;
    logic [NUM_BLK-1:0] lowest;

    assign seen[0] = 1'b0;

    // prefix-OR chain gives a one-hot of the lowest set bit
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | mask[i];
        assign lowest[i]  = mask[i] & ~seen[i];
    end

    assign any = seen[NUM_BLK];

    always_comb begin
        first = '0;
        for (int k = 0; k < NUM_BLK; k++) begin
            if (lowest[k]) first = first | BLK_W'(k);
        end
    end
endmodule

// File: rtl/efe_word_ctr.sv
module efe_word_ctr #(
    parameter int WORDS  = 8,
    parameter int WORD_W = efe_pkg::idx_w(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [WORD_W-1:0] idx,
    output logic              last
);
    assign last = (idx == WORD_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)     idx <= '0;
        else if (inc)       idx <= last ? '0 : idx + WORD_W'(1);
    end
endmodule

// File: rtl/efe_wait_timer.sv
module efe_wait_timer #(
    parameter int CYC = 5000,
    parameter int TW  = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic zero
);
    logic [TW-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= TW'(CYC - 1);
        else if (!zero)     cnt <= cnt - TW'(1);
    end
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
    import efe_pkg::*;
#(
    parameter int NUM_BLK       = 4,
    parameter int WORDS_PER_BLK = 8,
    parameter int DATA_W        = 16,
    parameter int MAX_PULSES    = 8,
    parameter int NOOP_WAIT     = 5000,
    localparam int BLK_W        = idx_w(NUM_BLK),
    localparam int WORD_W       = idx_w(WORDS_PER_BLK),
    localparam int ADDR_W       = BLK_W + WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               sw_reset,
    input  logic [NUM_BLK-1:0] sel_mask,
    input  logic [NUM_BLK-1:0] prot_mask,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic               arr_prog,
    output logic               arr_erase,
    input  logic [DATA_W-1:0]  arr_rdata,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [BLK_W-1:0]   fail_blk
);
    localparam int PW = $clog2(MAX_PULSES + 1);

    efe_state_e         state;
    logic [NUM_BLK-1:0] pending;
    logic [BLK_W-1:0]   cur_blk;
    logic [PW-1:0]      pulses;
    logic               done_q;
    logic [BLK_W-1:0]   fail_blk_q;

    logic [NUM_BLK-1:0] cur_oh;
    logic [NUM_BLK-1:0] pick_in;
    logic               pick_any;
    logic [BLK_W-1:0]   pick_first;
    logic [WORD_W-1:0]  word_idx;
    logic               word_last;
    logic               w_clr, w_inc, t_load, t_zero;
    logic               verify_bad;
    arr_strobe_t        strb;

    assign cur_oh  = NUM_BLK'(1) << cur_blk;
    // idle: fresh request; running: what remains after the current block
    assign pick_in = (state == ST_IDLE) ? (sel_mask & ~prot_mask)
                                        : (pending & ~cur_oh);

    efe_blk_picker #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) i_pick (
        .mask  (pick_in),
        .any   (pick_any),
        .first (pick_first)
    );

    efe_word_ctr #(.WORDS(WORDS_PER_BLK), .WORD_W(WORD_W)) i_word (
        .clk  (clk),
        .rst  (rst),
        .clr  (w_clr),
        .inc  (w_inc),
        .idx  (word_idx),
        .last (word_last)
    );

    efe_wait_timer #(.CYC(NOOP_WAIT)) i_wait (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .zero (t_zero)
    );

    assign verify_bad = (arr_rdata != {DATA_W{1'b1}});

    always_comb begin
        strb   = '0;
        w_clr  = 1'b0;
        w_inc  = 1'b0;
        t_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                w_clr  = 1'b1;
                t_load = start && !pick_any;
            end
            ST_PREP: begin
                strb.prog = 1'b1;
                w_inc     = 1'b1;
            end
            ST_ERASE: begin
                strb.erase = 1'b1;
                w_clr      = 1'b1;
            end
            ST_VERIFY: begin
                if (verify_bad) w_clr = 1'b1;
                else            w_inc = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pending    <= '0;
            cur_blk    <= '0;
            pulses     <= '0;
            done_q     <= 1'b0;
            fail_blk_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    pending <= pick_in;
                    if (pick_any) begin
                        cur_blk <= pick_first;
                        pulses  <= '0;
                        state   <= ST_PREP;
                    end else begin
                        state   <= ST_WAIT;
                    end
                end
                ST_PREP: if (word_last) state <= ST_ERASE;
                ST_ERASE: begin
                    pulses <= pulses + PW'(1);
                    state  <= ST_VERIFY;
                end
                ST_VERIFY: begin
                    if (verify_bad) begin
                        if (pulses == PW'(MAX_PULSES)) begin
                            fail_blk_q <= cur_blk;
                            state      <= ST_FAIL;
                        end else begin
                            state      <= ST_ERASE;
                        end
                    end else if (word_last) begin
                        pending <= pick_in;
                        if (pick_any) begin
                            cur_blk <= pick_first;
                            pulses  <= '0;
                            state   <= ST_PREP;
                        end else begin
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT: if (t_zero) begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                ST_FAIL: if (sw_reset) begin
                    fail_blk_q <= '0;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign arr_addr  = {cur_blk, word_idx};
    assign arr_prog  = strb.prog;
    assign arr_erase = strb.erase;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign fail      = (state == ST_FAIL);
    assign fail_blk  = fail_blk_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(arr_prog && arr_erase)); // R2
    AST_ERASE_TARGET: assert property (@(posedge clk) disable iff (rst)
        arr_erase |-> pending[cur_blk]); // R4
    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
        arr_erase |-> (pulses < PW'(MAX_PULSES))); // R6
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        fail |-> (busy && !arr_prog && !arr_erase)); // R7
    AST_FAIL_BLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fail && !sw_reset) |=> (fail && $stable(fail_blk))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !fail)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R10
endmodule

// File: tb/test_flash_erase_engine.sv
module test_flash_erase_engine;
    localparam int NB    = 4;
    localparam int W     = 8;
    localparam int DW    = 16;
    localparam int MAXP  = 8;
    localparam int WAITC = 5000;
    localparam int BW    = 2;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          sw_reset = 1'b0;
    logic [NB-1:0] sel_mask = '0;
    logic [NB-1:0] prot_mask = '0;
    logic [AW-1:0] arr_addr;
    logic          arr_prog, arr_erase;
    logic [DW-1:0] arr_rdata;
    logic          busy, done, fail;
    logic [BW-1:0] fail_blk;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flash_erase_engine #(
        .NUM_BLK(NB), .WORDS_PER_BLK(W), .DATA_W(DW),
        .MAX_PULSES(MAXP), .NOOP_WAIT(WAITC)
    ) i_flash_erase_engine (
        .clk(clk), .rst(rst), .start(start), .sw_reset(sw_reset),
        .sel_mask(sel_mask), .prot_mask(prot_mask),
        .arr_addr(arr_addr), .arr_prog(arr_prog), .arr_erase(arr_erase),
        .arr_rdata(arr_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_blk(fail_blk)
    );

    // behavioural array with erase-pulse fault injection
    logic [DW-1:0] mem [NB*W];
    int  need      [NB];
    int  prog_cnt  [NB];
    int  erase_cnt [NB];
    int  prep_bad;
    int  order_bad;
    int  last_blk;
    logic model_init = 1'b0;

    assign arr_rdata = mem[arr_addr];

    always @(posedge clk) begin
        if (model_init) begin
            for (int i = 0; i < NB*W; i++) mem[i] <= DW'(16'hA5A5 ^ i);
            for (int b = 0; b < NB; b++) begin
                prog_cnt[b]  = 0;
                erase_cnt[b] = 0;
            end
            prep_bad  = 0;
            order_bad = 0;
            last_blk  = -1;
        end else begin
            if (arr_prog) begin
                mem[arr_addr] <= '0;
                prog_cnt[int'(arr_addr) / W]++;
            end
            if (arr_erase) begin
                automatic int b = int'(arr_addr) / W;
                if (erase_cnt[b] == 0)
                    for (int k = 0; k < W; k++)
                        if (mem[b*W+k] != '0) prep_bad++;
                if (b < last_blk) order_bad++;
                last_blk = b;
                erase_cnt[b]++;
                if (erase_cnt[b] >= need[b])
                    for (int k = 0; k < W; k++) mem[b*W+k] <= '1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit blk_ones(input int b);
        for (int k = 0; k < W; k++) if (mem[b*W+k] != '1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit blk_orig(input int b);
        for (int k = 0; k < W; k++) if (mem[b*W+k] != DW'(16'hA5A5 ^ (b*W+k))) return 1'b0;
        return 1'b1;
    endfunction

    task automatic setup(input int n0, input int n1, input int n2, input int n3);
        need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
        @(negedge clk) model_init = 1'b1;
        @(negedge clk) model_init = 1'b0;
    endtask

    task automatic kick(input logic [NB-1:0] s, input logic [NB-1:0] p);
        sel_mask  = s;
        prot_mask = p;
        start     = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !arr_prog && !arr_erase, "R1 outputs in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !fail && fail_blk == 0 && !done, "R1 outputs after reset", int'(fail_blk), 0);
    endtask

    task automatic t_basic();
        int cyc;
        setup(1, 1, 3, 1);
        @(negedge clk);
        kick(4'b0101, 4'b0000);
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        wait_idle(cyc);
        chk(done == 1'b1, "R11 done with busy low", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done single cycle", int'(done), 0);
        chk(prog_cnt[0] == W && prog_cnt[2] == W, "R2 every word programmed", prog_cnt[2], W);
        chk(prep_bad == 0, "R2 zeros before first pulse", prep_bad, 0);
        chk(blk_ones(0) && blk_ones(2), "R3 blocks verified all ones", int'(blk_ones(2)), 1);
        chk(erase_cnt[0] == 1 && erase_cnt[2] == 3, "R6 pulse count matches need", erase_cnt[2], 3);
        chk(blk_orig(1) && blk_orig(3) && erase_cnt[1] == 0, "R4 unselected untouched", erase_cnt[1], 0);
        chk(order_bad == 0, "R5 ascending order", order_bad, 0);
    endtask

    task automatic t_protect();
        int cyc;
        setup(2, 1, 1, 2);
        @(negedge clk);
        kick(4'b1111, 4'b0110);
        wait_idle(cyc);
        chk(prog_cnt[1] == 0 && prog_cnt[2] == 0 && erase_cnt[1] == 0 && erase_cnt[2] == 0,
            "R4 protected no strobes", prog_cnt[1] + erase_cnt[2], 0);
        chk(blk_orig(1) && blk_orig(2), "R4 protected data kept", int'(blk_orig(2)), 1);
        chk(blk_ones(0) && blk_ones(3), "R3 unprotected erased", int'(blk_ones(3)), 1);
        chk(order_bad == 0 && last_blk == 3, "R5 last block highest", last_blk, 3);
    endtask

    task automatic t_noop();
        int cyc;
        setup(1, 1, 1, 1);
        @(negedge clk);
        kick(4'b0011, 4'b0011);
        wait_idle(cyc);
        chk(cyc == WAITC, "R9 no-op busy length", cyc, WAITC);
        chk(done == 1'b1, "R9 done after no-op wait", int'(done), 1);
        chk(prog_cnt[0] + prog_cnt[1] + erase_cnt[0] + erase_cnt[1] == 0,
            "R9 no array strobes", prog_cnt[0] + erase_cnt[0], 0);
    endtask

    task automatic t_fail();
        int cyc;
        setup(1, 2, 100, 1);
        @(negedge clk);
        kick(4'b1110, 4'b0000);
        cyc = 0;
        while (!fail && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        chk(fail && busy, "R7 locked busy and fail", int'(fail), 1);
        chk(fail_blk == 2, "R7 failing block index", int'(fail_blk), 2);
        chk(erase_cnt[2] == MAXP, "R6 pulse limit reached", erase_cnt[2], MAXP);
        chk(erase_cnt[3] == 0 && prog_cnt[3] == 0, "R7 later block untouched", prog_cnt[3], 0);
        chk(blk_ones(1), "R3 earlier block erased", int'(blk_ones(1)), 1);
        kick(4'b0001, 4'b0000);
        repeat (10) @(negedge clk);
        chk(fail && prog_cnt[0] == 0, "R8 start ignored when failed", prog_cnt[0], 0);
        sw_reset = 1'b1;
        @(negedge clk) sw_reset = 1'b0;
        chk(!busy && !fail, "R8 sw_reset returns to Read", int'(busy), 0);
    endtask

    task automatic t_ignore();
        int cyc;
        setup(2, 2, 1, 1);
        @(negedge clk);
        kick(4'b0011, 4'b0000);
        repeat (4) @(negedge clk);
        sel_mask = 4'b1100;
        start    = 1'b1;
        sw_reset = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        sw_reset = 1'b0;
        chk(busy == 1'b1, "R10 sw_reset ignored while running", int'(busy), 1);
        wait_idle(cyc);
        chk(blk_ones(0) && blk_ones(1), "R10 original job completed", int'(blk_ones(1)), 1);
        chk(prog_cnt[2] + prog_cnt[3] + erase_cnt[2] + erase_cnt[3] == 0,
            "R10 new start ignored", prog_cnt[2] + prog_cnt[3], 0);
    endtask

    task automatic t_hwreset();
        int snap;
        setup(1, 1, 1, 1);
        @(negedge clk);
        kick(4'b0001, 4'b0000);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !arr_prog && !arr_erase, "R12 reset stops erase", int'(busy), 0);
        snap = prog_cnt[0];
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(prog_cnt[0] == snap && erase_cnt[0] == 0, "R12 no activity after reset", erase_cnt[0], 0);
        chk(!busy && !fail, "R1 idle after mid-run reset", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        setup(1, 1, 1, 1);
        t_reset();
        t_basic();
        t_protect();
        t_noop();
        t_fail();
        t_ignore();
        t_hwreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule